// File: doc/BRIEF.md
# Complementary Dead-Time Output Stage

This stage sits between a pair of PWM generators and their two output pins. When dead-time insertion is off, each channel's raw waveform passes straight through to its own pin. When it is on, the second channel stops using its own generator. It instead drives the inverse of the first channel's waveform, so the two pins form a complementary pair.

A programmable gap, counted in prescaler ticks, holds back every rising edge. This keeps both switches of a half bridge from conducting at the same time. Falling edges are never delayed. After the gap stage, each channel passes through three per-channel stages in turn: a polarity inverse, an output inverter and an output enable. A disabled channel drives its pin low.

A register stage sits on the waveform path, so a change on a raw input appears on a pin one clock later. Changes to the inversion and enable controls reach the pins in the same cycle.

Top module: `pwm_deadtime_out`

## Requirements
- R1: After reset, both internal waveform states are low. With all inversion and enable controls at 0, both pins read 0.
- R2: With `dt_en` = 0, channel A carries `raw_a` and channel B carries `raw_b`. Each is delayed by one clock, with no gap inserted.
- R3: With `dt_en` = 1, channel B is driven from the inverse of `raw_a`, and `raw_b` has no effect on it.
- R4: With `dt_en` = 1, a channel's waveform goes low one clock after its source goes low. It goes high only once its source has stayed high while `dead_len` tick-qualified clocks have passed, and then on the following clock. With `tick` high on every clock, a source pulse of L clocks gives an output pulse of L − `dead_len` clocks.
- R5: With `dt_en` = 1 and `dead_len` = 0, the pair is a plain complementary pair with one clock of latency and no gap.
- R6: With `dt_en` = 1, a source pulse of `dead_len` clocks or fewer (with `tick` high every clock) is swallowed, and the output stays low for it.
- R7: The gap counter advances only on clocks where `tick` is 1. While `tick` is held at 0 and `dead_len` > 0, a waiting output stays low.
- R8: Once `dt_en` has been 1 for more than one clock, the two waveforms are never both high.
- R9: The pin value is the waveform XOR `pol_inv[i]` XOR `out_inv[i]`. Bit 0 belongs to channel A and bit 1 to channel B, so setting both stages cancels the inversion.
- R10: When `out_en[i]` is 0, that channel's pin is 0, whatever its waveform or inversion settings are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled count enable for the gap counter |
| raw_a | input | 1 | Raw PWM waveform, channel A |
| raw_b | input | 1 | Raw PWM waveform, channel B (unused when dead-time is on) |
| dt_en | input | 1 | Dead-time insertion and complementary pairing enable |
| dead_len | input | IW | Gap length in ticks |
| pol_inv | input | 2 | Polarity inverse per channel (bit 0 = A) |
| out_inv | input | 2 | Output inverter per channel (bit 0 = A) |
| out_en | input | 2 | Pin enable per channel (bit 0 = A) |
| pin_a | output | 1 | Pin drive, channel A |
| pin_b | output | 1 | Pin drive, channel B |

## Verification
The hardest situations to reach are those where the gap interacts with sparse ticks or with a change of mode in the middle of a waveform. Examples are a source that rises while `tick` is stalled, or `dt_en` switching on while one channel is already high.

The bench drives long sweeps of random pulse lengths around each gap value. It covers both every-clock and every-other-clock ticks and toggles the mode between runs. A cycle-level reference predicts every pin on every clock. Directed runs then pin down exact pulse widths, stalled ticks and the largest gap.

// File: rtl/pwm_deadtime_out.sv
module pwm_deadtime_out #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          raw_a,
  input  logic          raw_b,
  input  logic          dt_en,
  input  logic [IW-1:0] dead_len,
  input  logic [1:0]    pol_inv,
  input  logic [1:0]    out_inv,
  input  logic [1:0]    out_en,
  output logic          pin_a,
  output logic          pin_b
);

  logic [1:0]    src;
  logic [1:0]    core;
  logic [IW-1:0] cnt [2];

  assign src = {dt_en ? ~raw_a : raw_b, raw_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core <= '0;
      for (int i = 0; i < 2; i++) cnt[i] <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (!dt_en) begin
          core[i] <= src[i];
          cnt[i]  <= '0;
        end else if (!src[i]) begin
          core[i] <= 1'b0;
          cnt[i]  <= '0;
        end else if (!core[i]) begin
          if (cnt[i] >= dead_len) core[i] <= 1'b1;
          else if (tick)          cnt[i]  <= cnt[i] + 1'b1;
        end
      end
    end
  end

  assign pin_a = out_en[0] & (core[0] ^ pol_inv[0] ^ out_inv[0]);
  assign pin_b = out_en[1] & (core[1] ^ pol_inv[1] ^ out_inv[1]);

endmodule

module pwm_deadtime_chk #(
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dt_en,
  input logic          raw_a,
  input logic          raw_b,
  input logic [IW-1:0] dead_len,
  input logic [1:0]    core,
  input logic [1:0]    out_en,
  input logic          pin_a,
  input logic          pin_b
);

  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && dt_en && $past(dt_en) |-> !(core[0] && core[1]));

  p_fall_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(dt_en) && !$past(raw_a) |-> !core[0]);

  p_gap_before_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) && $past(dt_en) && $past(dt_en, 2) && $past(dead_len) != 0
    && $rose(core[0]) |-> $past(raw_a) && $past(raw_a, 2));

  p_comp_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(dt_en) && $past(raw_a) |-> !core[1]);

  p_independent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(dt_en) |-> core[1] == $past(raw_b) && core[0] == $past(raw_a));

  p_off_pins_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en[0] |-> !pin_a) and (!out_en[1] |-> !pin_b));

endmodule

bind pwm_deadtime_out pwm_deadtime_chk #(.IW(IW)) i_chk (
  .clk(clk), .rst_n(rst_n), .dt_en(dt_en), .raw_a(raw_a), .raw_b(raw_b),
  .dead_len(dead_len), .core(core), .out_en(out_en), .pin_a(pin_a), .pin_b(pin_b)
);

// File: tb/test_pwm_deadtime_out.sv
module test_pwm_deadtime_out;
  logic clk = 0, rst_n = 0, tick = 1, raw_a = 0, raw_b = 0, dt_en = 0;
  logic [7:0] dead_len = 0;
  logic [1:0] pol_inv = 0, out_inv = 0, out_en = 0;
  logic pin_a, pin_b;
  int total = 0, fails = 0;
  logic m_core [2];
  int   m_tc [2];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  pwm_deadtime_out #(.IW(8)) i_pwm_deadtime_out (
    .clk(clk), .rst_n(rst_n), .tick(tick), .raw_a(raw_a), .raw_b(raw_b),
    .dt_en(dt_en), .dead_len(dead_len), .pol_inv(pol_inv), .out_inv(out_inv),
    .out_en(out_en), .pin_a(pin_a), .pin_b(pin_b));

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_pin(int i);
    return out_en[i] & (m_core[i] ^ pol_inv[i] ^ out_inv[i]);
  endfunction

  task automatic step(string tag);
    logic s;
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      s = (i == 0) ? raw_a : (dt_en ? ~raw_a : raw_b);
      if (!dt_en) begin m_core[i] = s; m_tc[i] = 0; end
      else if (!s) begin m_core[i] = 0; m_tc[i] = 0; end
      else if (!m_core[i]) begin
        if (m_tc[i] >= int'(dead_len)) m_core[i] = 1;
        else if (tick) m_tc[i]++;
      end
    end
    @(negedge clk);
    chk({tag, " pin_a"}, pin_a, exp_pin(0));
    chk({tag, " pin_b"}, pin_b, exp_pin(1));
  endtask

  function automatic logic [15:0] nxt(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int lens [5] = '{0, 1, 2, 3, 6};
    int hold_a, hold_b, hi, first;
    m_core[0] = 0; m_core[1] = 0; m_tc[0] = 0; m_tc[1] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset pin_a", pin_a, 1'b0);
    chk("R1 reset pin_b", pin_b, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release pin_a", pin_a, 1'b0);
    chk("R1 after release pin_b", pin_b, 1'b0);

    hold_a = 0; hold_b = 0;
    for (int dm = 0; dm < 2; dm++)
      for (int ni = 0; ni < 5; ni++)
        for (int tk = 0; tk < 2; tk++) begin
          dt_en = dm[0]; dead_len = 8'(lens[ni]);
          for (int c = 0; c < 200; c++) begin
            lfsr = nxt(lfsr);
            tick = (tk == 0) ? 1'b1 : c[0];
            if (hold_a == 0) begin raw_a = ~raw_a; hold_a = 1 + int'(lfsr[3:0] % 9); end
            else hold_a--;
            if (hold_b == 0) begin raw_b = ~raw_b; hold_b = 1 + int'(lfsr[7:4] % 7); end
            else hold_b--;
            if (c % 16 == 0) begin
              pol_inv = lfsr[9:8]; out_inv = lfsr[11:10];
              out_en = (lfsr[13:12] == 0) ? 2'b11 : lfsr[13:12];
            end
            if (!dt_en) step("R2 independent");
            else if (dead_len == 0) step("R5 zero gap");
            else step("R4 gap");
            if (dt_en && c > 1 && pol_inv == 0 && out_inv == 0 && out_en == 2'b11)
              chk("R8 no overlap", pin_a & pin_b, 1'b0);
          end
        end

    pol_inv = 0; out_inv = 0; out_en = 2'b11; tick = 1;
    dt_en = 1; dead_len = 4; raw_a = 0; raw_b = 1;
    repeat (8) step("R3 settle");
    chk("R3 raw_b ignored, pin_b follows inverse of raw_a", pin_b, 1'b1);
    raw_b = 0; step("R3 raw_b low");
    chk("R3 raw_b low has no effect", pin_b, 1'b1);
    hi = 0; raw_a = 1;
    for (int k = 0; k < 4; k++) begin step("R6 short"); hi += pin_a; end
    raw_a = 0;
    for (int k = 0; k < 8; k++) begin step("R6 short tail"); hi += pin_a; end
    chk("R6 pulse of 4 swallowed", hi == 0, 1'b1);
    hi = 0; raw_a = 1;
    for (int k = 0; k < 6; k++) begin step("R4 width"); hi += pin_a; end
    raw_a = 0;
    for (int k = 0; k < 8; k++) begin step("R4 width tail"); hi += pin_a; end
    chk("R4 6-clock pulse gives 2-clock output", hi == 2, 1'b1);

    dead_len = 2; tick = 0; hi = 0; raw_a = 1;
    for (int k = 0; k < 10; k++) begin step("R7 stalled"); hi += pin_a; end
    chk("R7 stalled tick holds output low", hi == 0, 1'b1);
    tick = 1;
    step("R7 resume"); chk("R7 low after 1 tick", pin_a, 1'b0);
    step("R7 resume"); chk("R7 low after 2 ticks", pin_a, 1'b0);
    step("R7 resume"); chk("R7 high after gap", pin_a, 1'b1);

    dt_en = 0; raw_b = 1;
    step("R2 both high");
    for (int p = 0; p < 4; p++) begin
      pol_inv = {p[1], p[0]}; out_inv = {p[0], p[1]};
      #1;
      chk("R9 pin_a inversion", pin_a, 1'b1 ^ p[0] ^ p[1]);
      chk("R9 pin_b inversion", pin_b, 1'b1 ^ p[1] ^ p[0]);
    end
    pol_inv = 2'b11; out_inv = 2'b00; #1;
    chk("R9 polarity inverse alone A", pin_a, 1'b0);
    out_inv = 2'b11; #1;
    chk("R9 both stages cancel A", pin_a, 1'b1);
    chk("R9 both stages cancel B", pin_b, 1'b1);
    out_en = 2'b00; #1;
    chk("R10 disabled A", pin_a, 1'b0);
    chk("R10 disabled B", pin_b, 1'b0);
    out_en = 2'b01; #1;
    chk("R10 enabled A only", pin_a, 1'b1);
    chk("R10 disabled B only", pin_b, 1'b0);

    pol_inv = 0; out_inv = 0; out_en = 2'b11;
    dt_en = 1; dead_len = 255; raw_a = 0;
    repeat (5) step("R4 long settle");
    raw_a = 1; first = -1;
    for (int k = 1; k <= 300; k++) begin
      step("R4 long gap");
      if (pin_a && first < 0) first = k;
    end
    chk("R4 gap 255 rises on clock 256", first == 256, 1'b1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule